// File: doc/BRIEF.md
# Host Command Wrapper Controller

This controller sits between a host message channel and a processor datapath that it treats as a black box. The host sends command parcels one at a time. Each parcel carries a 2-bit opcode, an address and a 32-bit data word. The controller answers every parcel with exactly one response, which carries the opcode back, an error flag and a 32-bit data word. The exchange is stop-and-wait: a new parcel is taken only after the previous response has been consumed.

There are four commands. Two preload commands write the instruction memory and the register file before a run. A start command raises the run signal to the datapath. A collect command reads back results after the run. A run ends when the datapath raises its halt input, or when a cycle limit is reached.

While a run is in progress, the controller keeps a copy of the register file. The copy is updated from the datapath's writeback port. The controller also counts elapsed cycles, retired instructions and branch mispredicts. After the run, the collect command reads any of these registers or counters, one word per command.

Top module: `host_cmd_ctrl`

## Requirements
- R1: While a response is pending, `cmd_ready` is low. `rsp_op`, `rsp_err` and `rsp_data` hold steady until the cycle in which `rsp_ready` is high.
- R2: A parcel accepted on a clock edge (`cmd_valid` and `cmd_ready` both high) produces `rsp_valid` high in the next cycle. `rsp_op` equals the accepted opcode.
- R3: Opcode 0 loads the instruction memory. With no run in progress, it pulses `imem_we` for exactly one cycle, together with `imem_addr` and `imem_wdata` taken from the parcel. The response data echoes the parcel data.
- R4: Opcode 1 loads the register file, on `rf_we`/`rf_addr`/`rf_wdata` and in the shadow copy, and the response data echoes the parcel data. Register 0 is read-only: a load or writeback aimed at it is dropped, and it always reads back as 0. An index of RF_DEPTH or more is answered with an error.
- R5: Opcode 2 starts a run. `dp_run` is high from the cycle after acceptance. All three statistics restart from 0. The response data is 0.
- R6: A run ends after the first running cycle in which `dp_halt` is high, and that cycle is counted. Without a halt, the run ends after exactly MAX_CYCLES running cycles.
- R7: Statistics advance only in running cycles. The cycle count adds one per running cycle. The retired count adds one per cycle with `wb_valid` high. The mispredict count adds one per cycle with `wb_mispredict` high.
- R8: In a running cycle, `wb_we` high with a nonzero `wb_addr` overwrites that shadow register with `wb_data`.
- R9: Opcode 3 collects a result, chosen by the parcel address:
  - Addresses below RF_DEPTH return the shadow register.
  - RF_DEPTH returns the cycle count.
  - RF_DEPTH+1 returns the retired count.
  - RF_DEPTH+2 returns the mispredict count.
  - Any higher address returns an error.
- R10: While `dp_run` is high, every command is answered with `rsp_err` high and data 0. The command has no effect: no write pulse, no shadow change and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command parcel present |
| cmd_ready | output | 1 | Controller can take a parcel |
| cmd_op | input | 2 | Opcode: 0 load instruction memory, 1 load register, 2 start run, 3 collect |
| cmd_addr | input | ADDR_W | Address field of the parcel |
| cmd_data | input | 32 | Data field of the parcel |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_op | output | 2 | Echoed opcode |
| rsp_err | output | 1 | Command was rejected |
| rsp_data | output | 32 | Response data word |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | ADDR_W | Instruction memory write address |
| imem_wdata | output | 32 | Instruction memory write data |
| rf_we | output | 1 | Register file preload strobe |
| rf_addr | output | RF_IDX_W | Register file preload index |
| rf_wdata | output | 32 | Register file preload data |
| dp_run | output | 1 | Datapath runs while high |
| dp_halt | input | 1 | Datapath reached its end |
| wb_valid | input | 1 | An instruction retired this cycle |
| wb_we | input | 1 | Writeback writes a register |
| wb_addr | input | RF_IDX_W | Writeback register index |
| wb_data | input | 32 | Writeback value |
| wb_mispredict | input | 1 | A branch mispredict resolved this cycle |

## Verification
A wrong run flag shows up at once: `dp_run` stays high past a halt or a limit, or a command that should be rejected is accepted within two cycles of its parcel. A counter that is cleared wrongly, or that advances outside a run, appears only at the next collect of that statistic. The bench therefore reads every statistic after both a halted run and a limit-terminated run. Corrupted shadow registers, including a write that leaks into register 0, are exposed by collecting each register the bench has modelled. Loads rejected during a run are then confirmed harmless by the absence of strobes and by unchanged readback values.

// File: rtl/hcw_pkg.sv
package hcw_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_LOAD_IMEM = 2'd0,
        OP_LOAD_REG  = 2'd1,
        OP_RUN       = 2'd2,
        OP_COLLECT   = 2'd3
    } hcw_op_e;

    typedef struct packed {
        hcw_op_e             op;
        logic                err;
        logic [WORD_W-1:0]   data;
    } hcw_rsp_t;

    typedef struct packed {
        logic cycles;
        logic retired;
        logic mispredicts;
    } hcw_stat_sel_t;

    function automatic logic [WORD_W-1:0] sat_inc(input logic [WORD_W-1:0] v, input logic en);
        if (en && v != {WORD_W{1'b1}})
            return v + 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/hcw_run_ctrl.sv
module hcw_run_ctrl
    import hcw_pkg::*;
#(
    parameter int MAX_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              halt,
    input  logic              retire,
    input  logic              mispredict,
    output logic              running,
    output logic [WORD_W-1:0] cyc_cnt,
    output logic [WORD_W-1:0] ret_cnt,
    output logic [WORD_W-1:0] mis_cnt
);
    localparam logic [WORD_W-1:0] LAST_CYCLE = WORD_W'(MAX_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cyc_cnt <= '0;
            ret_cnt <= '0;
            mis_cnt <= '0;
        end else if (start) begin
            running <= 1'b1;
            cyc_cnt <= '0;
            ret_cnt <= '0;
            mis_cnt <= '0;
        end else if (running) begin
            cyc_cnt <= sat_inc(cyc_cnt, 1'b1);
            ret_cnt <= sat_inc(ret_cnt, retire);
            mis_cnt <= sat_inc(mis_cnt, mispredict);
            if (halt || cyc_cnt == LAST_CYCLE)
                running <= 1'b0;
        end
    end
endmodule

// File: rtl/hcw_shadow_rf.sv
module hcw_shadow_rf
    import hcw_pkg::*;
#(
    parameter int RF_DEPTH = 16,
    localparam int IDX_W = $clog2(RF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [IDX_W-1:0]  pre_idx,
    input  logic [WORD_W-1:0] pre_data,
    input  logic              wb_we,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [WORD_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] regs [RF_DEPTH];

    for (genvar i = 0; i < RF_DEPTH; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_store
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wb_we && wb_idx == IDX_W'(i))
                    q <= wb_data;
                else if (pre_we && pre_idx == IDX_W'(i))
                    q <= pre_data;
            end
            assign regs[i] = q;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/hcw_cmd_fsm.sv
module hcw_cmd_fsm
    import hcw_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int RF_DEPTH = 16,
    localparam int IDX_W = $clog2(RF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  hcw_op_e           cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    output hcw_rsp_t          rsp,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    input  logic              running,
    input  logic [WORD_W-1:0] reg_rd_data,
    input  logic [WORD_W-1:0] cyc_cnt,
    input  logic [WORD_W-1:0] ret_cnt,
    input  logic [WORD_W-1:0] mis_cnt,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              start,
    output logic              pre_we,
    output logic              imem_we,
    output logic [ADDR_W-1:0] imem_addr,
    output logic [WORD_W-1:0] imem_wdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_addr,
    output logic [WORD_W-1:0] rf_wdata
);
    localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'(RF_DEPTH);

    logic              accept;
    logic              err_c;
    logic [WORD_W-1:0] data_c;
    logic              do_imem, do_rf, do_start;
    hcw_stat_sel_t     sel;

    assign cmd_ready = !rsp_valid;
    assign accept    = cmd_valid && cmd_ready;
    assign rd_idx    = cmd_addr[IDX_W-1:0];

    always_comb begin
        sel.cycles      = cmd_addr == STAT_BASE;
        sel.retired     = cmd_addr == STAT_BASE + 1'b1;
        sel.mispredicts = cmd_addr == STAT_BASE + 2'd2;
    end

    always_comb begin
        err_c    = running;
        data_c   = '0;
        do_imem  = 1'b0;
        do_rf    = 1'b0;
        do_start = 1'b0;
        unique case (cmd_op)
            OP_LOAD_IMEM: begin
                do_imem = !running;
            end
            OP_LOAD_REG: begin
                err_c = running || cmd_addr >= STAT_BASE;
                do_rf = !err_c && rd_idx != '0;
            end
            OP_RUN: begin
                do_start = !running;
            end
            OP_COLLECT: begin
                if (cmd_addr < STAT_BASE)
                    data_c = reg_rd_data;
                else if (sel.cycles)
                    data_c = cyc_cnt;
                else if (sel.retired)
                    data_c = ret_cnt;
                else if (sel.mispredicts)
                    data_c = mis_cnt;
                else
                    err_c = 1'b1;
            end
            default: err_c = 1'b1;
        endcase
        if (!err_c && (cmd_op == OP_LOAD_IMEM || cmd_op == OP_LOAD_REG))
            data_c = cmd_data;
        if (err_c)
            data_c = '0;
    end

    assign start  = accept && do_start;
    assign pre_we = accept && do_rf;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp        <= '0;
            imem_we    <= 1'b0;
            imem_addr  <= '0;
            imem_wdata <= '0;
            rf_we      <= 1'b0;
            rf_addr    <= '0;
            rf_wdata   <= '0;
        end else begin
            imem_we <= accept && do_imem;
            rf_we   <= accept && do_rf;
            if (accept) begin
                rsp_valid <= 1'b1;
                rsp.op    <= cmd_op;
                rsp.err   <= err_c;
                rsp.data  <= data_c;
                if (do_imem) begin
                    imem_addr  <= cmd_addr;
                    imem_wdata <= cmd_data;
                end
                if (do_rf) begin
                    rf_addr  <= rd_idx;
                    rf_wdata <= cmd_data;
                end
            end else if (rsp_valid && rsp_ready) begin
                rsp_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/host_cmd_ctrl.sv
module host_cmd_ctrl
    import hcw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int RF_DEPTH   = 16,
    parameter int MAX_CYCLES = 1000,
    localparam int RF_IDX_W  = $clog2(RF_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [31:0]         cmd_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [1:0]          rsp_op,
    output logic                rsp_err,
    output logic [31:0]         rsp_data,
    output logic                imem_we,
    output logic [ADDR_W-1:0]   imem_addr,
    output logic [31:0]         imem_wdata,
    output logic                rf_we,
    output logic [RF_IDX_W-1:0] rf_addr,
    output logic [31:0]         rf_wdata,
    output logic                dp_run,
    input  logic                dp_halt,
    input  logic                wb_valid,
    input  logic                wb_we,
    input  logic [RF_IDX_W-1:0] wb_addr,
    input  logic [31:0]         wb_data,
    input  logic                wb_mispredict
);
    hcw_rsp_t              rsp;
    logic                  start, pre_we, running;
    logic [RF_IDX_W-1:0]   rd_idx;
    logic [WORD_W-1:0]     reg_rd_data, cyc_cnt, ret_cnt, mis_cnt;

    hcw_cmd_fsm #(.ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH)) u_fsm (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(hcw_op_e'(cmd_op)), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp(rsp), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .running(running), .reg_rd_data(reg_rd_data),
        .cyc_cnt(cyc_cnt), .ret_cnt(ret_cnt), .mis_cnt(mis_cnt),
        .rd_idx(rd_idx), .start(start), .pre_we(pre_we),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
    );

    hcw_run_ctrl #(.MAX_CYCLES(MAX_CYCLES)) u_run (
        .clk(clk), .rst(rst), .start(start), .halt(dp_halt),
        .retire(wb_valid), .mispredict(wb_mispredict),
        .running(running), .cyc_cnt(cyc_cnt), .ret_cnt(ret_cnt), .mis_cnt(mis_cnt)
    );

    hcw_shadow_rf #(.RF_DEPTH(RF_DEPTH)) u_rf (
        .clk(clk), .rst(rst),
        .pre_we(pre_we), .pre_idx(rd_idx), .pre_data(cmd_data),
        .wb_we(running && wb_we), .wb_idx(wb_addr), .wb_data(wb_data),
        .rd_idx(rd_idx), .rd_data(reg_rd_data)
    );

    assign dp_run   = running;
    assign rsp_op   = rsp.op;
    assign rsp_err  = rsp.err;
    assign rsp_data = rsp.data;
endmodule

// File: rtl/hcw_checker.sv
module hcw_checker #(
    parameter int ADDR_W   = 10,
    parameter int RF_IDX_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [1:0]          cmd_op,
    input logic [ADDR_W-1:0]   cmd_addr,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic [1:0]          rsp_op,
    input logic                rsp_err,
    input logic [31:0]         rsp_data,
    input logic                imem_we,
    input logic [ADDR_W-1:0]   imem_addr,
    input logic                rf_we,
    input logic [RF_IDX_W-1:0] rf_addr,
    input logic                dp_run,
    input logic                dp_halt
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_ready_low_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready);

    p_hold_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_op) && $stable(rsp_err));

    p_echo_op_r2: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid && rsp_op == $past(cmd_op));

    p_imem_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_op == 2'd0 && !dp_run |=> imem_we && imem_addr == $past(cmd_addr));

    p_reg_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> rf_addr != '0);

    p_start_r5: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_op == 2'd2 && !dp_run |=> dp_run);

    p_halt_stop_r6: assert property (@(posedge clk) disable iff (rst)
        dp_run && dp_halt |=> !dp_run);

    p_reject_r10: assert property (@(posedge clk) disable iff (rst)
        acc && dp_run |=> rsp_err && rsp_data == '0 && !imem_we && !rf_we);
endmodule

bind host_cmd_ctrl hcw_checker #(.ADDR_W(ADDR_W), .RF_IDX_W(RF_IDX_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_op(rsp_op), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .imem_we(imem_we), .imem_addr(imem_addr), .rf_we(rf_we), .rf_addr(rf_addr),
    .dp_run(dp_run), .dp_halt(dp_halt)
);

// File: tb/tb_host_cmd_ctrl.sv
module tb_host_cmd_ctrl;
    localparam int ADDR_W = 10;
    localparam int RF_DEPTH = 16;
    localparam int MAXC = 50;
    localparam int IW = 4;
    localparam int NV = 9;
    // fields: op(2) addr(10) data(32) exp_err(1) exp_data(32)
    localparam logic [76:0] VEC [NV] = '{
        {2'd1, 10'd3,  32'h1111_0003, 1'b0, 32'h1111_0003},
        {2'd1, 10'd12, 32'hC0DE_000C, 1'b0, 32'hC0DE_000C},
        {2'd1, 10'd0,  32'h0000_DEAD, 1'b0, 32'h0000_DEAD},
        {2'd1, 10'd16, 32'h0000_BEEF, 1'b1, 32'h0},
        {2'd0, 10'd5,  32'hA5A5_0005, 1'b0, 32'hA5A5_0005},
        {2'd3, 10'd3,  32'h0,         1'b0, 32'h1111_0003},
        {2'd3, 10'd0,  32'h0,         1'b0, 32'h0},
        {2'd3, 10'd19, 32'h0,         1'b1, 32'h0},
        {2'd3, 10'd16, 32'h0,         1'b0, 32'h0}
    };

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, rsp_ready = 0;
    logic [1:0] cmd_op = 0;
    logic [ADDR_W-1:0] cmd_addr = 0;
    logic [31:0] cmd_data = 0;
    logic cmd_ready, rsp_valid, rsp_err, imem_we, rf_we, dp_run;
    logic [1:0] rsp_op;
    logic [31:0] rsp_data, imem_wdata, rf_wdata;
    logic [ADDR_W-1:0] imem_addr;
    logic [IW-1:0] rf_addr;
    logic dp_halt = 0, wb_valid = 0, wb_we = 0, wb_mispredict = 0;
    logic [IW-1:0] wb_addr = 0;
    logic [31:0] wb_data = 0;

    int checks = 0, errors = 0;
    int n_imem = 0, n_rf = 0;
    logic [ADDR_W-1:0] last_imem_addr;
    logic [31:0] last_imem_data;
    int k = 0, halt_at = 0;
    int exp_cyc = 0, exp_ret = 0, exp_mis = 0;
    logic [31:0] exp_rf [RF_DEPTH];

    always #10 clk = ~clk;

    host_cmd_ctrl #(.ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH), .MAX_CYCLES(MAXC)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
        .rsp_err(rsp_err), .rsp_data(rsp_data),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .dp_run(dp_run), .dp_halt(dp_halt), .wb_valid(wb_valid), .wb_we(wb_we),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_mispredict(wb_mispredict)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (imem_we) begin
            n_imem++;
            last_imem_addr = imem_addr;
            last_imem_data = imem_wdata;
        end
        if (rf_we) n_rf++;
    end

    // datapath model and expected statistics
    always @(negedge clk) begin
        if (dp_run) begin
            k++;
            wb_valid      = (k % 4) != 0;
            wb_mispredict = (k % 3) == 0;
            wb_we         = (k % 2) == 0;
            wb_addr       = IW'(k % 8);
            wb_data       = 32'(k * 7 + 32'h100);
            dp_halt       = (k == halt_at);
            exp_cyc++;
            if (wb_valid) exp_ret++;
            if (wb_mispredict) exp_mis++;
            if (wb_we && wb_addr != 0) exp_rf[wb_addr] = wb_data;
        end else begin
            wb_valid = 0; wb_mispredict = 0; wb_we = 0; dp_halt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        output logic e, output logic [31:0] rd, output logic [1:0] ro);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        chk("R2 rsp_valid next cycle", 32'(rsp_valid), 32'd1);
        e = rsp_err; rd = rsp_data; ro = rsp_op;
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
    endtask

    task automatic wait_idle();
        while (dp_run) @(negedge clk);
    endtask

    initial begin
        logic e;
        logic [31:0] rd;
        logic [1:0] ro;
        for (int i = 0; i < RF_DEPTH; i++) exp_rf[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("reset cmd_ready", 32'(cmd_ready), 1);
        chk("reset rsp_valid", 32'(rsp_valid), 0);
        chk("R5 reset dp_run", 32'(dp_run), 0);

        // vector walk: preload, rejection of bad index, collect (R2 R3 R4 R9)
        for (int i = 0; i < NV; i++) begin
            logic [76:0] v;
            v = VEC[i];
            send(v[76:75], v[74:65], v[64:33], e, rd, ro);
            chk($sformatf("R2 vec%0d op echo", i), 32'(ro), 32'(v[76:75]));
            chk($sformatf("R9 vec%0d err", i), 32'(e), 32'(v[32]));
            chk($sformatf("R4 vec%0d data", i), rd, v[31:0]);
        end
        exp_rf[3] = 32'h1111_0003;
        exp_rf[12] = 32'hC0DE_000C;
        chk("R3 imem strobes", n_imem, 1);
        chk("R3 imem addr", 32'(last_imem_addr), 5);
        chk("R3 imem data", last_imem_data, 32'hA5A5_0005);
        chk("R4 rf strobes (reg0/oob dropped)", n_rf, 2);

        // R1: response held while host not ready
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd3; cmd_addr = 10'd12;
        @(negedge clk);
        cmd_valid = 0;
        for (int j = 0; j < 3; j++) begin
            chk("R1 pending valid", 32'(rsp_valid), 1);
            chk("R1 ready low", 32'(cmd_ready), 0);
            chk("R1 data held", rsp_data, 32'hC0DE_000C);
            @(negedge clk);
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk("R1 released", 32'(rsp_valid), 0);

        // halted run (R5 R6 R7 R8 R10)
        k = 0; halt_at = 20; exp_cyc = 0; exp_ret = 0; exp_mis = 0;
        send(2'd2, 0, 32'h1234, e, rd, ro);
        chk("R5 run err", 32'(e), 0);
        chk("R5 run data", rd, 0);
        chk("R5 dp_run high", 32'(dp_run), 1);
        send(2'd1, 10'd12, 32'h5555_5555, e, rd, ro);
        chk("R10 load reg during run err", 32'(e), 1);
        chk("R10 load reg data", rd, 0);
        send(2'd0, 10'd7, 32'h6666_6666, e, rd, ro);
        chk("R10 load imem during run err", 32'(e), 1);
        send(2'd3, 10'd16, 0, e, rd, ro);
        chk("R10 collect during run err", 32'(e), 1);
        send(2'd2, 0, 0, e, rd, ro);
        chk("R10 restart during run err", 32'(e), 1);
        wait_idle();
        chk("R10 no imem strobe", n_imem, 1);
        chk("R10 no rf strobe", n_rf, 2);
        send(2'd3, 10'd16, 0, e, rd, ro);
        chk("R6 halted cycle count", rd, 32'(halt_at));
        chk("R7 cycles model", rd, 32'(exp_cyc));
        send(2'd3, 10'd17, 0, e, rd, ro);
        chk("R7 retired", rd, 32'(exp_ret));
        send(2'd3, 10'd18, 0, e, rd, ro);
        chk("R7 mispredicts", rd, 32'(exp_mis));
        for (int r = 0; r < RF_DEPTH; r++) begin
            send(2'd3, ADDR_W'(r), 0, e, rd, ro);
            chk($sformatf("R8 shadow reg%0d", r), rd, exp_rf[r]);
        end

        // limit-terminated run (R6 R7)
        k = 0; halt_at = 0; exp_cyc = 0; exp_ret = 0; exp_mis = 0;
        send(2'd2, 0, 0, e, rd, ro);
        chk("R5 second run accepted", 32'(e), 0);
        wait_idle();
        send(2'd3, 10'd16, 0, e, rd, ro);
        chk("R6 limit cycles", rd, 32'(MAXC));
        send(2'd3, 10'd17, 0, e, rd, ro);
        chk("R7 retired restarted", rd, 32'(exp_ret));
        send(2'd3, 10'd18, 0, e, rd, ro);
        chk("R7 mispredicts restarted", rd, 32'(exp_mis));
        send(2'd3, 10'd4, 0, e, rd, ro);
        chk("R8 reg4 after limit run", rd, exp_rf[4]);
        send(2'd3, 10'd0, 0, e, rd, ro);
        chk("R4 reg0 reads zero", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule